// File: doc/BRIEF.md
# Block Storage DMA Controller

This block sits in the I/O region of a 32-bit physical address space and moves whole storage blocks between main memory and a block store without processor involvement. Software sets a memory address, then writes a command word that names the direction, the block number and whether an interrupt is wanted. The block then copies one 4096-byte block, a 32-bit word at a time, over two handshaken master ports: one toward main memory and one toward the block store.

Three registers are decoded on a simple single-cycle bus slave port: a command register at 0xF0000000, a memory-address register at 0xF0000004 and a status register at 0xF0000008. Reads return data combinationally in the same cycle. While a block is moving, the status register reports busy and further commands are dropped. Completion is signalled by busy falling and, when requested, a one-cycle interrupt pulse.

Top module: `blkdisk_top`

## Requirements
- R1: After reset the status, command and memory-address registers read 0, `irq` is 0 and neither `memReq` nor `stoReq` is asserted; no request is raised while idle.
- R2: A bus read at 0xF0000000 returns the latched command: bit 0 direction, bit 1 interrupt enable, bits 21:2 block number, bits 31:22 zero; 0xF0000004 returns the last written memory address; any other address reads 0.
- R3: The status register at 0xF0000008 reads 1 in bit 0 while a transfer is in progress and 0 otherwise; bits 31:1 always read 0.
- R4: A bus write to 0xF0000000 while idle starts a transfer; status reads busy in the cycle after the write, and busy never rises without such a write.
- R5: Direction 0 copies storage words 0 to 1023 of the named block, in increasing order, to memory addresses start, start+4, ... start+4092, where start is the memory-address register at the time of the command; exactly 1024 words are written.
- R6: Direction 1 reads memory from start upward in steps of 4 and writes the words to storage indices 0 to 1023 of the named block, in order, with the block number on `stoBlock`.
- R7: A command write while busy is ignored: the command readback stays unchanged, the running transfer keeps its direction, block and address, and no second transfer follows.
- R8: Writing the memory-address register during a transfer updates its readback but does not move the addresses of the transfer in flight.
- R9: With interrupt enable 1, `irq` is high for exactly one cycle, the first cycle in which status reads idle; with interrupt enable 0 it stays low.
- R10: Once `memReq` or `stoReq` is raised it stays high with address, index, write flag and write data unchanged until the matching acknowledge is sampled.
- R11: `memReq` and `stoReq` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus slave access in this cycle |
| busWe | input | 1 | Bus access is a write |
| busAddr | input | 32 | Bus byte address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, same cycle |
| memReq | output | 1 | Memory master request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| stoReq | output | 1 | Block store request |
| stoWe | output | 1 | Block store request is a write |
| stoBlock | output | 20 | Block number of the transfer |
| stoIndex | output | 10 | Word index inside the block |
| stoWdata | output | 32 | Block store write data |
| stoAck | input | 1 | Block store accepts the request this cycle |
| stoRdata | input | 32 | Block store read data, valid with `stoAck` |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench goes after the word ordering and the final word: a counter that stops one short or runs one long leaves a word missing or writes past the block, and an address step that is off shows up as out-of-order or misplaced memory words. Acknowledges are withheld at pseudo-random cycles so that a design that drops or changes a request before its acknowledge, or that grabs data on a stale acknowledge, corrupts the copied contents. A command written mid-transfer and a memory-address rewrite mid-transfer catch a design that restarts, switches direction or follows the live register. The interrupt is checked both for landing in the first idle cycle and for staying silent when disabled, which exposes a level instead of a pulse or an ignored enable.

// File: rtl/blkdisk_pkg.sv
package blkdisk_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xferState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;    // latch command and clear the word counter
    logic rdPhase;  // source request is active
    logic wrPhase;  // destination request is active
    logic grab;     // capture source data
    logic step;     // advance to next word
    logic finish;   // last destination word accepted
  } xferStrobe_t;

endpackage

// File: rtl/blkdisk_ctrl.sv
module blkdisk_ctrl
  import blkdisk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrite,
  input  logic        srcAck,
  input  logic        dstAck,
  input  logic        lastWord,
  input  logic        irqEn,
  output xferStrobe_t stb,
  output logic        busy,
  output logic        irq
);

  xferState_t state, stateNext;

  always_comb begin
    stateNext = state;
    stb = '0;
    unique case (state)
      XS_IDLE: begin
        if (ctlWrite) begin
          stb.start = 1'b1;
          stateNext = XS_READ;
        end
      end
      XS_READ: begin
        stb.rdPhase = 1'b1;
        if (srcAck) begin
          stb.grab  = 1'b1;
          stateNext = XS_WRITE;
        end
      end
      XS_WRITE: begin
        stb.wrPhase = 1'b1;
        if (dstAck) begin
          if (lastWord) begin
            stb.finish = 1'b1;
            stateNext  = XS_IDLE;
          end else begin
            stb.step  = 1'b1;
            stateNext = XS_READ;
          end
        end
      end
      default: stateNext = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= XS_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      irq   <= stb.finish & irqEn;
    end
  end

  assign busy = (state != XS_IDLE);

endmodule

// File: rtl/blkdisk_dp.sv
module blkdisk_dp
  import blkdisk_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          BLK_W   = 20,
  parameter int          WORDS   = 1024,
  parameter logic [31:0] IO_BASE = 32'hF000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  xferStrobe_t        stb,
  input  logic               busy,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               ctlWrite,
  output logic               srcAck,
  output logic               dstAck,
  output logic               lastWord,
  output logic               irqEn,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic               memAck,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               stoReq,
  output logic               stoWe,
  output logic [BLK_W-1:0]   stoBlock,
  output logic [$clog2(WORDS)-1:0] stoIndex,
  output logic [DATA_W-1:0]  stoWdata,
  input  logic               stoAck,
  input  logic [DATA_W-1:0]  stoRdata
);

  localparam int IDX_W   = $clog2(WORDS);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] CTL_ADR  = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] MADR_ADR = ADDR_W'(IO_BASE + 32'd4);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(IO_BASE + 32'd8);

  logic              cmdStore;
  logic [BLK_W-1:0]  blockReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] startAddr;
  logic [IDX_W-1:0]  wordCnt;
  logic [DATA_W-1:0] dataBuf;
  logic              addrWrite;

  assign ctlWrite  = busSel & busWe & (busAddr == CTL_ADR);
  assign addrWrite = busSel & busWe & (busAddr == MADR_ADR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStore  <= 1'b0;
      irqEn     <= 1'b0;
      blockReg  <= '0;
      addrReg   <= '0;
      startAddr <= '0;
      wordCnt   <= '0;
      dataBuf   <= '0;
    end else begin
      if (addrWrite) addrReg <= busWdata[ADDR_W-1:0];
      if (stb.start) begin
        cmdStore  <= busWdata[0];
        irqEn     <= busWdata[1];
        blockReg  <= busWdata[2 +: BLK_W];
        startAddr <= addrReg;
        wordCnt   <= '0;
      end
      if (stb.grab) dataBuf <= cmdStore ? memRdata : stoRdata;
      if (stb.step) wordCnt <= wordCnt + 1'b1;
    end
  end

  assign lastWord = (wordCnt == IDX_W'(WORDS - 1));
  assign srcAck   = cmdStore ? memAck : stoAck;
  assign dstAck   = cmdStore ? stoAck : memAck;

  assign memReq   = (stb.rdPhase & cmdStore) | (stb.wrPhase & ~cmdStore);
  assign memWe    = stb.wrPhase & ~cmdStore;
  assign memAddr  = startAddr + (ADDR_W'(wordCnt) << BYTE_SH);
  assign memWdata = dataBuf;

  assign stoReq   = (stb.rdPhase & ~cmdStore) | (stb.wrPhase & cmdStore);
  assign stoWe    = stb.wrPhase & cmdStore;
  assign stoBlock = blockReg;
  assign stoIndex = wordCnt;
  assign stoWdata = dataBuf;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWe) begin
      if (busAddr == CTL_ADR) begin
        busRdata[0]          = cmdStore;
        busRdata[1]          = irqEn;
        busRdata[2 +: BLK_W] = blockReg;
      end else if (busAddr == MADR_ADR) begin
        busRdata = DATA_W'(addrReg);
      end else if (busAddr == STAT_ADR) begin
        busRdata[0] = busy;
      end
    end
  end

endmodule

// File: rtl/blkdisk_top.sv
module blkdisk_top
  import blkdisk_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          BLK_W       = 20,
  parameter int          BLOCK_BYTES = 4096,
  parameter logic [31:0] IO_BASE     = 32'hF000_0000,
  localparam int         WORDS       = BLOCK_BYTES / (DATA_W / 8),
  localparam int         IDX_W       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              stoReq,
  output logic              stoWe,
  output logic [BLK_W-1:0]  stoBlock,
  output logic [IDX_W-1:0]  stoIndex,
  output logic [DATA_W-1:0] stoWdata,
  input  logic              stoAck,
  input  logic [DATA_W-1:0] stoRdata,
  output logic              irq
);

  xferStrobe_t stb;
  logic busy, ctlWrite, srcAck, dstAck, lastWord, irqEn;

  blkdisk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrite (ctlWrite),
    .srcAck   (srcAck),
    .dstAck   (dstAck),
    .lastWord (lastWord),
    .irqEn    (irqEn),
    .stb      (stb),
    .busy     (busy),
    .irq      (irq)
  );

  blkdisk_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BLK_W   (BLK_W),
    .WORDS   (WORDS),
    .IO_BASE (IO_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .ctlWrite (ctlWrite),
    .srcAck   (srcAck),
    .dstAck   (dstAck),
    .lastWord (lastWord),
    .irqEn    (irqEn),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memAck   (memAck),
    .memRdata (memRdata),
    .stoReq   (stoReq),
    .stoWe    (stoWe),
    .stoBlock (stoBlock),
    .stoIndex (stoIndex),
    .stoWdata (stoWdata),
    .stoAck   (stoAck),
    .stoRdata (stoRdata)
  );

endmodule

// File: rtl/blkdisk_chk.sv
module blkdisk_chk #(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          IDX_W   = 10,
  parameter int          WORDS   = 1024,
  parameter logic [31:0] IO_BASE = 32'hF000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              stoReq,
  input logic              stoWe,
  input logic              stoAck,
  input logic [IDX_W-1:0]  stoIndex,
  input logic [DATA_W-1:0] stoWdata,
  input logic              irq,
  input logic              busy
);

  logic [IDX_W:0] doneCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) doneCnt <= '0;
    else if ((memReq && memWe && memAck) || (stoReq && stoWe && stoAck))
      doneCnt <= doneCnt + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !stoReq));

  p_status_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == ADDR_W'(IO_BASE + 32'd8)) |->
      (busRdata[DATA_W-1:1] == '0 && busRdata[0] == busy));

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busSel && busWe && busAddr == ADDR_W'(IO_BASE)));

  p_word_total_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneCnt == (IDX_W+1)'(WORDS));

  p_irq_place_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && $past(busy)));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_sto_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stoReq && !stoAck) |=>
      (stoReq && $stable(stoIndex) && $stable(stoWe) && $stable(stoWdata)));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && stoReq));

endmodule

bind blkdisk_top blkdisk_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W),
  .WORDS   (WORDS),
  .IO_BASE (IO_BASE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .stoReq   (stoReq),
  .stoWe    (stoWe),
  .stoAck   (stoAck),
  .stoIndex (stoIndex),
  .stoWdata (stoWdata),
  .irq      (irq),
  .busy     (busy)
);

// File: tb/sim_blkdisk_top.sv
module sim_blkdisk_top;

  localparam logic [31:0] CTL  = 32'hF000_0000;
  localparam logic [31:0] MADR = 32'hF000_0004;
  localparam logic [31:0] STAT = 32'hF000_0008;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0, busRdata;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic        stoReq, stoWe, stoAck = 1'b0;
  logic [19:0] stoBlock;
  logic [9:0]  stoIndex;
  logic [31:0] stoWdata, stoRdata = '0;
  logic        irq;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  blkdisk_top u0 (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .stoReq(stoReq), .stoWe(stoWe), .stoBlock(stoBlock), .stoIndex(stoIndex),
    .stoWdata(stoWdata), .stoAck(stoAck), .stoRdata(stoRdata),
    .irq(irq)
  );

  // Bench models of memory and block store
  logic [31:0] memArr [0:4095];
  logic [31:0] stoArr [0:1023];
  logic        waitMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] memExpAddr = '0;
  int          stoExpIdx = 0;
  logic [19:0] expBlock = '0;
  int memWrites = 0, memReads = 0, stoWrites = 0, stoReads = 0;
  int orderErr = 0, stabErr = 0, overlapErr = 0, irqCount = 0, waitHits = 0;
  logic        memPend = 1'b0, stoPend = 1'b0;
  logic [31:0] pMemAddr = '0, pMemData = '0, pStoData = '0;
  logic [9:0]  pStoIdx = '0;
  logic        pMemWe = 1'b0, pStoWe = 1'b0;

  function automatic logic [31:0] patt(logic [19:0] blk, int idx);
    logic [9:0] i10;
    i10 = idx[9:0];
    return {blk[11:0], 2'b10, i10, 8'h5C};
  endfunction

  always @(negedge clk) begin
    logic goM, goS;
    if (irq) irqCount++;
    if (memReq && stoReq) overlapErr++;
    if (memPend && (!memReq || memAddr != pMemAddr || memWe != pMemWe ||
                    (memWe && memWdata != pMemData))) stabErr++;
    if (stoPend && (!stoReq || stoIndex != pStoIdx || stoWe != pStoWe ||
                    (stoWe && stoWdata != pStoData))) stabErr++;
    goM = waitMode ? lfsr[0] : 1'b1;
    goS = waitMode ? lfsr[3] : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memAck = memReq && goM;
    stoAck = stoReq && goS;
    if ((memReq && !goM) || (stoReq && !goS)) waitHits++;
    if (memAck) begin
      if (memAddr != memExpAddr || memAddr[31:14] != 0) orderErr++;
      memExpAddr = memExpAddr + 32'd4;
      if (memWe) begin
        memArr[memAddr[13:2]] = memWdata;
        memWrites++;
      end else begin
        memRdata = memArr[memAddr[13:2]];
        memReads++;
      end
    end
    if (stoAck) begin
      if (int'(stoIndex) != stoExpIdx || stoBlock != expBlock) orderErr++;
      stoExpIdx++;
      if (stoWe) begin
        stoArr[stoIndex] = stoWdata;
        stoWrites++;
      end else begin
        stoRdata = patt(stoBlock, int'(stoIndex));
        stoReads++;
      end
    end
    memPend = memReq && !memAck;  pMemAddr = memAddr; pMemWe = memWe; pMemData = memWdata;
    stoPend = stoReq && !stoAck;  pStoIdx = stoIndex; pStoWe = stoWe; pStoData = stoWdata;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(logic [31:0] a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #0.5;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic resetCounters(logic [31:0] start, logic [19:0] blk);
    memExpAddr = start; stoExpIdx = 0; expBlock = blk;
    memWrites = 0; memReads = 0; stoWrites = 0; stoReads = 0; irqCount = 0;
  endtask

  // Polls status each cycle; returns irq seen in the first idle cycle
  task automatic waitDone(output logic irqAtFall);
    logic [31:0] s;
    irqAtFall = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      busRead(STAT, s);
      if (s[0] == 1'b0) begin
        irqAtFall = irq;
        return;
      end
    end
    check("watchdog waitDone", 32'd1, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    @(negedge clk);
    busRead(STAT, v);  check("R1 status after reset", v, 32'h0);
    busRead(CTL, v);   check("R1 command after reset", v, 32'h0);
    busRead(MADR, v);  check("R1 address after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 no request after reset", {30'b0, memReq, stoReq}, 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    busWrite(MADR, 32'h0000_1000);
    busRead(MADR, v);          check("R2 address readback", v, 32'h0000_1000);
    busRead(32'hF000_000C, v); check("R2 unused address reads 0", v, 32'h0);
  endtask

  task automatic testLoad();
    logic [31:0] v, cmd;
    logic fallIrq;
    int bad = 0;
    cmd = (32'h12345 << 2) | 32'h2;
    resetCounters(32'h0000_1000, 20'h12345);
    busWrite(CTL, cmd);
    busRead(STAT, v);  check("R4 busy after command", v, 32'h1);
    check("R3 status upper bits", v >> 1, 32'h0);
    busRead(CTL, v);   check("R2 command readback", v, cmd);
    waitDone(fallIrq);
    check("R9 irq in first idle cycle", {31'b0, fallIrq}, 32'h1);
    @(negedge clk);
    check("R9 irq single pulse", irqCount, 32'd1);
    for (int i = 0; i < 1024; i++)
      if (memArr[1024 + i] !== patt(20'h12345, i)) bad++;
    check("R5 load data mismatches", bad, 32'd0);
    check("R5 load word count", memWrites, 32'd1024);
    check("R5 load order", orderErr, 32'd0);
    check("R1 idle after load", {30'b0, memReq, stoReq}, 32'h0);
  endtask

  task automatic testStore();
    logic fallIrq;
    int bad = 0;
    for (int i = 0; i < 1024; i++) memArr[2048 + i] = 32'hC0DE_0000 ^ (i * 32'h0101_0003);
    waitMode = 1'b1;
    orderErr = 0;
    resetCounters(32'h0000_2000, 20'h00ABC);
    busWrite(MADR, 32'h0000_2000);
    busWrite(CTL, (32'h00ABC << 2) | 32'h1);
    waitDone(fallIrq);
    check("R9 no irq when disabled", {31'b0, fallIrq}, 32'h0);
    @(negedge clk);
    check("R9 no irq count when disabled", irqCount, 32'd0);
    for (int i = 0; i < 1024; i++)
      if (stoArr[i] !== (32'hC0DE_0000 ^ (i * 32'h0101_0003))) bad++;
    check("R6 store data mismatches", bad, 32'd0);
    check("R6 store word count", stoWrites, 32'd1024);
    check("R6 store order and block", orderErr, 32'd0);
    check("R10 wait states exercised", {31'b0, waitHits > 0}, 32'h1);
    waitMode = 1'b0;
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v, cmd;
    logic fallIrq;
    int bad = 0;
    cmd = (32'h00005 << 2) | 32'h2;
    orderErr = 0;
    resetCounters(32'h0000_3000, 20'h00005);
    busWrite(MADR, 32'h0000_3000);
    busWrite(CTL, cmd);
    repeat (40) @(negedge clk);
    busWrite(CTL, (32'h00007 << 2) | 32'h1);
    busRead(CTL, v);   check("R7 command unchanged while busy", v, cmd);
    busWrite(MADR, 32'h0000_0000);
    busRead(MADR, v);  check("R8 address readback updated", v, 32'h0);
    waitDone(fallIrq);
    check("R9 irq after busy-write run", {31'b0, fallIrq}, 32'h1);
    repeat (5) @(negedge clk);
    busRead(STAT, v);  check("R7 no second transfer", v, 32'h0);
    for (int i = 0; i < 1024; i++)
      if (memArr[3072 + i] !== patt(20'h00005, i)) bad++;
    check("R7 original transfer data", bad, 32'd0);
    check("R7 no store words", stoWrites, 32'd0);
    check("R8 addresses kept in flight", orderErr, 32'd0);
    check("R7 single transfer words", memWrites, 32'd1024);
    check("R9 one pulse only", irqCount, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testLoad();
    testStore();
    testBusyIgnore();
    check("R11 port overlap", overlapErr, 32'd0);
    check("R10 request hold", stabErr, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule